// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block turns single-word read and write requests into row and column phases on a small DRAM array that it contains. The array is a grid of multi-bit supercells. Each flat request address splits into a row part (upper bits) and a column part (lower bits). The two parts travel one after the other over one narrow shared address bus. A row strobe phase copies a whole row into an internal row buffer. A column strobe phase then reads or writes one supercell of that buffer.

The controller leaves the last row open. A request to the same row therefore needs only a column phase, which is fast page mode. A request to another row first writes the buffer back to the array in a precharge cycle, then opens the new row, then performs the column phase. A timer raises a refresh request every configurable number of cycles. Once the access in flight finishes, that refresh is served before any new request. A refresh closes the open row and restores the rows one at a time, in ascending order.

The strobes and the shared address bus are brought out as outputs so the command sequence can be observed.

Top module: `pagemode_dram_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, both strobes are 0 and no row is open, so the first access performs a row phase. Supercell at flat address a initially holds (3*a+1) mod 2^WORD_W.
- R2: The row is req_addr[ADDR_W-1:COL_BITS] and the column is req_addr[COL_BITS-1:0]. The row travels on bus_addr while bus_ras is 1, and the column travels on bus_addr while bus_cas is 1.
- R3: A read returns the addressed supercell on rsp_rdata with rsp_valid high for exactly one cycle, in the cycle right after the column phase.
- R4: A write stores req_wdata into the addressed supercell. Later reads return it, including after its row has been closed and reopened.
- R5: A request to the open row is served with a column phase alone: accept, then one column cycle, so the result comes 2 cycles after the accept cycle, with no row strobe.
- R6: A request to another row while a row is open takes a precharge cycle with both strobes low, then a row cycle, then a column cycle (result 4 cycles after accept). With no row open, the request takes a row cycle and a column cycle (3 cycles).
- R7: req_ready is 0 whenever the controller is in any cycle other than idle. A request is taken on a clock edge where req_valid and req_ready are both 1.
- R8: Every REFRESH_CYCLES cycles a refresh is raised. It shows on the bus as a row strobe cycle not followed by a column cycle, and its row address steps 0,1,...,ROWS-1 and then wraps.
- R9: A pending refresh holds req_ready low and is served before any new request once the current access ends. It closes the open row, so the next access performs a row phase even for the same row.
- R10: Stored data is unchanged by refresh cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_BITS+COL_BITS | Flat supercell address |
| req_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | WORD_W | Read data |
| bus_ras | output | 1 | Row strobe (access or refresh) |
| bus_cas | output | 1 | Column strobe |
| bus_addr | output | max(ROW_BITS,COL_BITS) | Shared row/column address bus |

## Verification
The hardest case to reach from the ports is a refresh that falls due while an access is in flight or a request is waiting. Only then does the priority rule decide the order, and only then is an open row closed behind the requester's back. The bench streams a long run of pseudo-random reads and writes across the refresh boundaries. For each access it predicts the latency from its own model of the open row, treating the row as closed whenever a refresh strobe was seen since the last access. Meanwhile a bus monitor checks the refresh row order and spacing, and a scoreboard checks every returned word.

// File: rtl/dram_pkg.sv
// Shared types for the page-mode DRAM controller.
// Assumes nothing beyond the states listed below.
package dram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,  // waiting for a request or a refresh
        ST_PRE,   // write row buffer back, close row
        ST_ACT,   // row strobe: load row into buffer
        ST_CAS,   // column strobe: read or write one supercell
        ST_REF    // refresh strobe on one row
    } ctl_state_t;
endpackage

// File: rtl/dram_grid.sv
// Cell array: ROWS x COLS supercells of WORD_W bits, stored one row per word.
// The row index is taken from the shared address bus. An activate latches
// that row for the later write-back, a precharge writes the buffer back into
// the latched row, and a refresh restores the row addressed on the bus.
// Assumes at most one of act/rfsh/pre is high in any cycle.
module dram_grid #(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    parameter int WORD_W   = 8,
    parameter int BUS_W    = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              act,
    input  logic                              rfsh,
    input  logic                              pre,
    input  logic [BUS_W-1:0]                  bus_addr,
    input  logic [(1<<COL_BITS)*WORD_W-1:0]   wb_data,
    output logic [(1<<COL_BITS)*WORD_W-1:0]   rd_data
);
    localparam int ROWS  = 1 << ROW_BITS;
    localparam int COLS  = 1 << COL_BITS;
    localparam int ROW_W = COLS * WORD_W;

    logic [ROW_W-1:0]    cells [ROWS];
    logic [ROW_BITS-1:0] row_sel;
    logic [ROW_BITS-1:0] latched_row;

    // Row index decoded from the shared bus.
    assign row_sel = bus_addr[ROW_BITS-1:0];
    assign rd_data = cells[row_sel];

    // Cell storage: seeded on reset, written back on precharge, restored on refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    cells[r][c*WORD_W +: WORD_W] <= WORD_W'((r*COLS + c)*3 + 1);
        end else if (pre) begin
            cells[latched_row] <= wb_data;
        end else if (rfsh) begin
            cells[row_sel] <= cells[row_sel];
        end
    end

    // Row latch: remembers which row the buffer belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n)   latched_row <= '0;
        else if (act) latched_row <= row_sel;
    end
endmodule

// File: rtl/row_buffer.sv
// Row buffer: holds one full row, loaded on activate. One supercell can be
// written per cycle, and the column read is combinational.
// Assumes load and wr_en are never high together.
module row_buffer #(
    parameter int COL_BITS = 2,
    parameter int WORD_W   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic [(1<<COL_BITS)*WORD_W-1:0]   load_data,
    input  logic                              wr_en,
    input  logic [COL_BITS-1:0]               col,
    input  logic [WORD_W-1:0]                 wdata,
    output logic [WORD_W-1:0]                 rdata,
    output logic [(1<<COL_BITS)*WORD_W-1:0]   row_data
);
    localparam int COLS = 1 << COL_BITS;

    logic [WORD_W-1:0] words [COLS];

    // Column select for reads.
    assign rdata = words[col];

    // Flatten the words for write-back.
    generate
        for (genvar g = 0; g < COLS; g++) begin : g_flat
            assign row_data[g*WORD_W +: WORD_W] = words[g];
        end
    endgenerate

    // Buffer storage: whole-row load or single-column write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < COLS; c++) words[c] <= '0;
        end else if (load) begin
            for (int c = 0; c < COLS; c++) words[c] <= load_data[c*WORD_W +: WORD_W];
        end else if (wr_en) begin
            words[col] <= wdata;
        end
    end
endmodule

// File: rtl/refresh_timer.sv
// Refresh timer: raises pending every PERIOD cycles and holds it until ack.
// Assumes PERIOD >= 2.
module refresh_timer #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int CNT_W = $clog2(PERIOD);

    logic [CNT_W-1:0] count;
    logic             wrap;

    assign wrap = (count == CNT_W'(PERIOD - 1));

    // Free-running interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (wrap) count <= '0;
        else           count <= count + 1'b1;
    end

    // Pending flag: set on wrap, cleared when the refresh is served.
    always_ff @(posedge clk) begin
        if (!rst_n)    pending <= 1'b0;
        else if (wrap) pending <= 1'b1;
        else if (ack)  pending <= 1'b0;
    end

    assert_pending_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending);
    assert_wrap_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> pending);
endmodule

// File: rtl/pagemode_dram_ctrl.sv
// Page-mode DRAM controller with its cell array. It takes one request at a
// time, splits the address into row and column, and drives them over one
// shared bus with row and column strobes. The last row stays open, so a
// request to the same row needs only a column strobe. Periodic refresh comes
// before new requests. Assumes the requester holds req_valid until
// req_ready is seen high.
module pagemode_dram_ctrl #(
    parameter int ROW_BITS       = 2,
    parameter int COL_BITS       = 2,
    parameter int WORD_W         = 8,
    parameter int REFRESH_CYCLES = 1000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic                           req_write,
    input  logic [ROW_BITS+COL_BITS-1:0]   req_addr,
    input  logic [WORD_W-1:0]              req_wdata,
    output logic                           rsp_valid,
    output logic [WORD_W-1:0]              rsp_rdata,
    output logic                           bus_ras,
    output logic                           bus_cas,
    output logic [((ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS)-1:0] bus_addr
);
    import dram_pkg::*;

    localparam int ADDR_W = ROW_BITS + COL_BITS;
    localparam int BUS_W  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;
    localparam int ROW_W  = (1 << COL_BITS) * WORD_W;

    ctl_state_t          state;
    logic                is_wr;
    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;
    logic [WORD_W-1:0]   wdata_q;
    logic                row_open;
    logic [ROW_BITS-1:0] open_row;
    logic                svc_ref;
    logic [ROW_BITS-1:0] ref_row;
    logic                ref_pend;
    logic [ROW_W-1:0]    grid_rd;
    logic [ROW_W-1:0]    buf_row;
    logic [WORD_W-1:0]   buf_rd;
    logic [ROW_BITS-1:0] req_row;
    logic [COL_BITS-1:0] req_col;

    assign req_row   = req_addr[ADDR_W-1:COL_BITS];
    assign req_col   = req_addr[COL_BITS-1:0];
    assign req_ready = (state == ST_IDLE) && !ref_pend;

    // Shared bus driver: row in activate/refresh, column in column phase.
    always_comb begin
        bus_ras  = (state == ST_ACT) || (state == ST_REF);
        bus_cas  = (state == ST_CAS);
        bus_addr = '0;
        case (state)
            ST_ACT:  bus_addr = BUS_W'(row_q);
            ST_REF:  bus_addr = BUS_W'(ref_row);
            ST_CAS:  bus_addr = BUS_W'(col_q);
            default: bus_addr = '0;
        endcase
    end

    dram_grid #(
        .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .WORD_W(WORD_W), .BUS_W(BUS_W)
    ) i_grid (
        .clk(clk), .rst_n(rst_n),
        .act(state == ST_ACT), .rfsh(state == ST_REF), .pre(state == ST_PRE),
        .bus_addr(bus_addr), .wb_data(buf_row), .rd_data(grid_rd)
    );

    row_buffer #(.COL_BITS(COL_BITS), .WORD_W(WORD_W)) i_rowbuf (
        .clk(clk), .rst_n(rst_n),
        .load(state == ST_ACT), .load_data(grid_rd),
        .wr_en((state == ST_CAS) && is_wr), .col(bus_addr[COL_BITS-1:0]),
        .wdata(wdata_q), .rdata(buf_rd), .row_data(buf_row)
    );

    refresh_timer #(.PERIOD(REFRESH_CYCLES)) i_refresh (
        .clk(clk), .rst_n(rst_n), .ack(state == ST_REF), .pending(ref_pend)
    );

    // Access sequencer: refresh first, then page hit, page miss or closed-row access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            is_wr    <= 1'b0;
            row_q    <= '0;
            col_q    <= '0;
            wdata_q  <= '0;
            row_open <= 1'b0;
            open_row <= '0;
            svc_ref  <= 1'b0;
            ref_row  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ref_pend) begin
                        svc_ref <= 1'b1;
                        state   <= row_open ? ST_PRE : ST_REF;
                    end else if (req_valid) begin
                        is_wr   <= req_write;
                        row_q   <= req_row;
                        col_q   <= req_col;
                        wdata_q <= req_wdata;
                        if (row_open && (req_row == open_row)) state <= ST_CAS;
                        else if (row_open)                     state <= ST_PRE;
                        else                                   state <= ST_ACT;
                    end
                end
                ST_PRE: begin
                    row_open <= 1'b0;
                    state    <= svc_ref ? ST_REF : ST_ACT;
                end
                ST_ACT: begin
                    row_open <= 1'b1;
                    open_row <= row_q;
                    state    <= ST_CAS;
                end
                ST_CAS: state <= ST_IDLE;
                ST_REF: begin
                    ref_row <= ref_row + 1'b1;
                    svc_ref <= 1'b0;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Read response register: one-cycle pulse after a read column phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state == ST_CAS) && !is_wr;
            if ((state == ST_CAS) && !is_wr) rsp_rdata <= buf_rd;
        end
    end

    assert_reset_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !row_open);
    assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_cas_open_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cas |-> row_open);
    assert_act_then_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACT) |=> bus_cas);
    assert_pre_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) |=> !row_open);
    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !req_ready);
    assert_ref_row_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REF) |=> (ref_row == $past(ref_row) + 1'b1));
    assert_refresh_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ref_pend) |=> (state == ST_PRE || state == ST_REF));
endmodule

// File: tb/test_pagemode_dram_ctrl.sv
module test_pagemode_dram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int REF_N      = 300;
    localparam int ROW_BITS   = 2;
    localparam int COL_BITS   = 2;
    localparam int WORD_W     = 8;
    localparam int ADDR_W     = ROW_BITS + COL_BITS;
    localparam int NWORDS     = 1 << ADDR_W;
    localparam int ROWS       = 1 << ROW_BITS;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORD_W-1:0] req_wdata = '0;
    logic              req_ready;
    logic              rsp_valid;
    logic [WORD_W-1:0] rsp_rdata;
    logic              bus_ras;
    logic              bus_cas;
    logic [1:0]        bus_addr;

    pagemode_dram_ctrl #(
        .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .WORD_W(WORD_W), .REFRESH_CYCLES(REF_N)
    ) i_pagemode_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_ras(bus_ras), .bus_cas(bus_cas), .bus_addr(bus_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    logic [WORD_W-1:0] model [NWORDS];
    logic [WORD_W-1:0] expq [$];
    bit  model_open = 0;
    int  model_row = 0;
    int  ref_events = 0;
    int  ref_seen = 0;
    int  act_count = 0;
    int  last_act_addr = -1;
    int  last_cas_addr = -1;
    int  cyc = 0;
    int  last_lat = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Bus monitor: classifies row strobes, checks refresh order and spacing (R8).
    int  exp_ref_row = 0;
    int  last_ref_cyc = -1;
    bit  p_ras = 0;
    int  p_addr = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_ras && bus_cas) begin
                act_count++;
                last_act_addr = p_addr;
            end
            if (p_ras && !bus_cas) begin
                chk(p_addr == exp_ref_row, "R8", "refresh row order", p_addr, exp_ref_row);
                if (last_ref_cyc >= 0)
                    chk((cyc - last_ref_cyc) >= REF_N - 6 && (cyc - last_ref_cyc) <= REF_N + 6,
                        "R8", "refresh spacing", cyc - last_ref_cyc, REF_N);
                last_ref_cyc = cyc;
                exp_ref_row = (exp_ref_row + 1) % ROWS;
                ref_events++;
            end
            if (bus_cas) last_cas_addr = int'(bus_addr);
            p_ras  = bus_ras;
            p_addr = int'(bus_addr);
        end
    end

    // Scoreboard monitor: pops one expected word per response (R3, R4, R10).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (expq.size() == 0) begin
                chk(0, "R3", "unexpected response", int'(rsp_rdata), -1);
            end else begin
                logic [WORD_W-1:0] e;
                e = expq.pop_front();
                chk(rsp_rdata == e, "R4/R10", "read data", int'(rsp_rdata), int'(e));
            end
        end
    end

    // Driver: issues one access, checks busy ready, latency and response timing.
    task automatic xfer(input bit we, input int addr, input logic [WORD_W-1:0] wd);
        int  lat;
        int  exp_lat;
        int  row;
        bit  saw_cas;
        row = addr >> COL_BITS;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = we;
        req_addr  = ADDR_W'(addr);
        req_wdata = wd;
        if (we) model[addr] = wd;
        else    expq.push_back(model[addr]);
        lat = 0;
        saw_cas = 0;
        while (!saw_cas && lat < 20) begin
            @(negedge clk);
            lat++;
            if (lat == 1) begin
                req_valid = 1'b0;
                chk(req_ready == 1'b0, "R7", "ready low while busy", int'(req_ready), 0);
            end
            if (bus_cas) saw_cas = 1;
        end
        @(negedge clk);
        lat++;
        #1;
        if (!we) chk(rsp_valid == 1'b1, "R3", "response one cycle after column", int'(rsp_valid), 1);
        if (ref_events != ref_seen) model_open = 0;
        ref_seen = ref_events;
        if (!model_open)           exp_lat = 3;
        else if (row == model_row) exp_lat = 2;
        else                       exp_lat = 4;
        chk(lat == exp_lat, "R5/R6/R9", "access latency", lat, exp_lat);
        model_open = 1;
        model_row  = row;
        last_lat   = lat;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        int acts0;
        for (int a = 0; a < NWORDS; a++) model[a] = WORD_W'(a*3 + 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);
        chk(bus_ras == 1'b0 && bus_cas == 1'b0, "R1", "strobes idle", int'({bus_ras, bus_cas}), 0);

        // R1/R6: first access opens a row (latency 3)
        xfer(0, 5, '0);
        chk(last_lat == 3, "R1", "first access uses row phase", last_lat, 3);
        chk(act_count == 1, "R1", "one row strobe", act_count, 1);
        // R5: same row, column only
        acts0 = act_count;
        xfer(0, 6, '0);
        xfer(1, 7, 8'h3C);
        xfer(0, 7, '0);
        chk(act_count == acts0, "R5", "no row strobe on page hits", act_count, acts0);
        // R2/R6: other row, row 3 column 2
        xfer(0, 14, '0);
        chk(last_lat == 4, "R6", "page miss latency", last_lat, 4);
        chk(last_act_addr == 3, "R2", "row on bus", last_act_addr, 3);
        chk(last_cas_addr == 2, "R2", "column on bus", last_cas_addr, 2);
        // R4: written word survives write-back and reopen
        xfer(0, 7, '0);
        for (int c = 0; c < 4; c++) xfer(1, c, WORD_W'(8'hE0 + c));
        for (int c = 3; c >= 0; c--) xfer(0, c, '0);
        xfer(0, 9, '0);
        xfer(0, 2, '0);

        // R8/R9/R10: long stream across refresh boundaries
        lfsr = 8'h5B;
        for (int i = 0; i < 320; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (lfsr[7:6] == 2'b11) xfer(1, int'(lfsr[3:0]), lfsr ^ 8'h96);
            else                    xfer(0, int'(lfsr[3:0]), '0);
        end
        repeat (4) @(negedge clk);
        chk(ref_events >= 3, "R8", "refreshes observed", ref_events, 3);
        chk(expq.size() == 0, "R3", "all responses received", expq.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule